// File: doc/BRIEF.md
# Performance Monitor Counter Triad

Three down-counters share one control register and are gated by a common arming condition. Software loads each counter with a start value and programs the control register. That register chooses four things: the arming source (an instruction mark pulse, one of six debug-comparator events, or unconditional), the event line to count (one of up to 32), a privilege filter for each of those two, and an operating mode.

In one-shot mode each counter signals once on reaching zero and then stops. In trace mode each counter copies its live value into a shadow register whenever a trace-capture request arrives. It keeps counting and wraps past zero to all-ones. The block reports a per-counter zero pulse, the live values and the shadow values.

Top module: `perf_triad`

## Requirements
- R1: After reset every live value, every shadow value and every zero pulse is 0, the armed flag is clear and no counter is enabled.
- R2: Writes use `wr_addr`: 0 writes the control register, and 1, 2 and 3 write the preload of counter 0, 1 and 2. Control fields are: mode at bits 2:1, counted-event select at 8:4, counted privilege at 13:12, enable source at 19:16 and enable privilege at 21:20.
- R3: Enable source codes are 0000 (never), 0001 (mark pulse), 0010..0111 (comparator event 0..5) and 1111 (always running). Codes 1000..1110 never run.
- R4: A qualifying arming pulse sets a sticky armed flag at the next edge, and counting begins at the edge after that.
- R5: Both privilege fields use the same encoding, with `priv_sup`=1 meaning supervisor: 00 any task, 01 user task with `tid_match`, 10 supervisor task, 11 supervisor task with `tid_match`. An arming pulse that fails the enable-privilege filter does not arm.
- R6: A running counter decrements by one on each edge where the selected event line is high and passes the counted-privilege filter. Other lines have no effect.
- R7: In one-shot mode (00), a counter that reaches zero clears its own enable and holds 0, while the other counters continue.
- R8: The armed flag clears on any control write. In one-shot mode it also clears when the last enabled counter stops.
- R9: In trace mode (01), a trace request copies the pre-edge live value into the shadow. The counter keeps counting and goes from 0 to all-ones.
- R10: Mode codes 10 and 11 stop all counting.
- R11: The zero pulse is high for exactly the one cycle after the edge on which the count becomes 0.
- R12: A preload write loads the live value and the shadow and re-enables a stopped counter. It has priority over counting and capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1..3 preload of counter 0..2 |
| wr_data | input | 32 | Write data |
| mark_pulse | input | 1 | Instruction mark event |
| cmp_evt | input | 6 | Debug-comparator events 0..5 |
| evt_lines | input | 32 | Countable event lines |
| priv_sup | input | 1 | Current task is supervisor |
| tid_match | input | 1 | Task-ID match flag |
| trace_req | input | 1 | Trace capture request |
| zero_evt | output | 3 | Per-counter zero pulse |
| cnt_val | output | 96 | Live values, counter i at bits 32i+31:32i |
| shadow_val | output | 96 | Shadow values, same packing |

## Verification
Counting is driven with the selected line held high while the privilege and task-ID inputs take combinations that pass or fail each filter. This separates the filter from the line select. A line other than the selected one is also raised, to show that only the chosen line is counted.

Arming is exercised with four kinds of pulse: a mark pulse, the wrong comparator, the right comparator under the wrong privilege, and the right comparator under the right privilege. These pin down the source decode and the one-edge arming latency.

Counters with different preloads expose one-shot stops that happen at different times, and a reload after all counters have stopped shows that the armed flag was cleared. Trace captures taken just after a wrap show both the all-ones value and the value sampled before the edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int DATA_W   = 32;
    localparam int SRC_W    = 4;
    localparam int PRIV_W   = 2;
    localparam int MODE_W   = 2;

    localparam logic [SRC_W-1:0]  SRC_OFF    = 4'h0;
    localparam logic [SRC_W-1:0]  SRC_MARK   = 4'h1;
    localparam logic [SRC_W-1:0]  SRC_CMP0   = 4'h2;
    localparam logic [SRC_W-1:0]  SRC_ALWAYS = 4'hF;

    typedef enum logic [MODE_W-1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_TRACE   = 2'b01,
        MODE_RSVD2   = 2'b10,
        MODE_RSVD3   = 2'b11
    } mode_e;

    typedef struct packed {
        logic [PRIV_W-1:0] en_priv;
        logic [SRC_W-1:0]  en_src;
        logic [PRIV_W-1:0] cnt_priv;
        logic [4:0]        evt_sel;
        mode_e             mode;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.mode     = mode_e'(d[2:1]);
        c.evt_sel  = d[8:4];
        c.cnt_priv = d[13:12];
        c.en_src   = d[19:16];
        c.en_priv  = d[21:20];
        return c;
    endfunction

    function automatic logic priv_pass(input logic [PRIV_W-1:0] code,
                                       input logic sup, input logic tid);
        case (code)
            2'b00:   return 1'b1;
            2'b01:   return !sup && tid;
            2'b10:   return sup;
            default: return sup && tid;
        endcase
    endfunction

endpackage

// File: rtl/pmc_arm.sv
module pmc_arm
    import pmc_pkg::*;
#(
    parameter int NUM_CMP = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic [SRC_W-1:0]   en_src,
    input  logic [PRIV_W-1:0]  en_priv,
    input  logic               mode_ok,
    input  logic               mark_pulse,
    input  logic [NUM_CMP-1:0] cmp_evt,
    input  logic               priv_sup,
    input  logic               tid_match,
    input  logic               stop_all,
    output logic               armed,
    output logic               run
);
    localparam int CMP_LAST = int'(SRC_CMP0) + NUM_CMP - 1;

    logic armed_q;
    logic src_pulse;
    logic src_valid;
    logic hit;

    always_comb begin
        src_pulse = 1'b0;
        src_valid = 1'b0;
        if (en_src == SRC_MARK) begin
            src_pulse = mark_pulse;
            src_valid = 1'b1;
        end else begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (int'(en_src) == int'(SRC_CMP0) + k) begin
                    src_pulse = cmp_evt[k];
                    src_valid = 1'b1;
                end
            end
        end
    end

    assign hit = src_valid && src_pulse && priv_pass(en_priv, priv_sup, tid_match);

    always_ff @(posedge clk) begin
        if (rst)           armed_q <= 1'b0;
        else if (ctrl_wr)  armed_q <= 1'b0;
        else if (stop_all) armed_q <= 1'b0;
        else if (hit)      armed_q <= 1'b1;
    end

    assign armed = armed_q;
    assign run   = mode_ok && ((en_src == SRC_ALWAYS) || (armed_q && src_valid));

    // R8
    armed_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !armed_q);

    // R4
    arm_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_wr && !stop_all && armed_q) |=> armed_q);

    // R3
    cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(en_src) > CMP_LAST && en_src != SRC_ALWAYS) |-> !run);

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             oneshot,
    input  logic             trace_mode,
    input  logic             trace_req,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] shadow,
    output logic             zero,
    output logic             en,
    output logic             stop_now
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, shadow_q;
    logic             zero_q, en_q;
    logic             step_eff;

    assign step_eff = step && (trace_mode || (oneshot && en_q));
    assign stop_now = !load && oneshot && en_q && step && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            shadow_q <= '0;
            zero_q   <= 1'b0;
            en_q     <= 1'b0;
        end else if (load) begin
            cnt_q    <= load_val;
            shadow_q <= load_val;
            zero_q   <= 1'b0;
            en_q     <= 1'b1;
        end else begin
            zero_q <= step_eff && (cnt_q == ONE);
            if (step_eff)               cnt_q    <= cnt_q - ONE;
            if (stop_now)               en_q     <= 1'b0;
            if (trace_mode && trace_req) shadow_q <= cnt_q;
        end
    end

    assign cnt    = cnt_q;
    assign shadow = shadow_q;
    assign zero   = zero_q;
    assign en     = en_q;

    // R11
    zero_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        zero_q |=> !zero_q);

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oneshot && !en_q && !load) |=> $stable(cnt_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(cnt_q));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !(trace_mode && trace_req)) |=> $stable(shadow_q));

    // R12
    load_en_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (en_q && !zero_q));

endmodule

// File: rtl/perf_triad.sv
module perf_triad
    import pmc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_CNT = 3,
    parameter int NUM_CMP = 6,
    parameter int NUM_EVT = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     mark_pulse,
    input  logic [NUM_CMP-1:0]       cmp_evt,
    input  logic [NUM_EVT-1:0]       evt_lines,
    input  logic                     priv_sup,
    input  logic                     tid_match,
    input  logic                     trace_req,
    output logic [NUM_CNT-1:0]       zero_evt,
    output logic [NUM_CNT*CNT_W-1:0] cnt_val,
    output logic [NUM_CNT*CNT_W-1:0] shadow_val
);
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    ctrl_t              ctrl_q;
    logic               ctrl_wr;
    logic               mode_ok, oneshot, trace_mode;
    logic               run, armed;
    logic               evt_hit, cnt_step;
    logic               stop_all;
    logic [NUM_CNT-1:0] load, en, stop_now, done;
    logic [SEL_W-1:0]   sel;

    assign ctrl_wr = wr_en && (wr_addr == 2'd0);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= unpack_ctrl(wr_data);
    end

    assign oneshot    = (ctrl_q.mode == MODE_ONESHOT);
    assign trace_mode = (ctrl_q.mode == MODE_TRACE);
    assign mode_ok    = oneshot || trace_mode;

    assign sel      = SEL_W'(ctrl_q.evt_sel);
    assign evt_hit  = (int'(ctrl_q.evt_sel) < NUM_EVT) && evt_lines[sel];
    assign cnt_step = run && evt_hit && priv_pass(ctrl_q.cnt_priv, priv_sup, tid_match);

    assign stop_all = oneshot && (|stop_now) && (&done);

    pmc_arm #(.NUM_CMP(NUM_CMP)) u_arm (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .en_src     (ctrl_q.en_src),
        .en_priv    (ctrl_q.en_priv),
        .mode_ok    (mode_ok),
        .mark_pulse (mark_pulse),
        .cmp_evt    (cmp_evt),
        .priv_sup   (priv_sup),
        .tid_match  (tid_match),
        .stop_all   (stop_all),
        .armed      (armed),
        .run        (run)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign load[i] = wr_en && (int'(wr_addr) == i + 1);
        assign done[i] = !(en[i] || load[i]) || stop_now[i];

        pmc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .load       (load[i]),
            .load_val   (wr_data[CNT_W-1:0]),
            .step       (cnt_step),
            .oneshot    (oneshot),
            .trace_mode (trace_mode),
            .trace_req  (trace_req),
            .cnt        (cnt_val[i*CNT_W +: CNT_W]),
            .shadow     (shadow_val[i*CNT_W +: CNT_W]),
            .zero       (zero_evt[i]),
            .en         (en[i]),
            .stop_now   (stop_now[i])
        );
    end

    // R10
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_ok && !(|load)) |=> $stable(cnt_val));

    // R8
    last_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_all && !ctrl_wr) |=> !armed);

endmodule

// File: tb/tb_perf_triad.sv
`timescale 1ns/100ps
module tb_perf_triad;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          mark_pulse = 1'b0;
    logic [5:0]    cmp_evt = '0;
    logic [31:0]   evt_lines = '0;
    logic          priv_sup = 1'b0;
    logic          tid_match = 1'b0;
    logic          trace_req = 1'b0;
    logic [2:0]    zero_evt;
    logic [95:0]   cnt_val, shadow_val;

    perf_triad dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mark_pulse(mark_pulse), .cmp_evt(cmp_evt), .evt_lines(evt_lines),
        .priv_sup(priv_sup), .tid_match(tid_match), .trace_req(trace_req),
        .zero_evt(zero_evt), .cnt_val(cnt_val), .shadow_val(shadow_val)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          due;
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = cnt_val[it.idx*W +: W];
                1:       act = shadow_val[it.idx*W +: W];
                default: act = {29'd0, zero_evt};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic expect_item(input int kind, input int idx, input logic [31:0] v,
                               input string req);
        item_t it;
        it.due = cyc; it.kind = kind; it.idx = idx; it.exp = v; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic exp_cnt(input int i, input logic [31:0] v, input string r);
        expect_item(0, i, v, r);
    endtask
    task automatic exp_sh(input int i, input logic [31:0] v, input string r);
        expect_item(1, i, v, r);
    endtask
    task automatic exp_zero(input logic [2:0] v, input string r);
        expect_item(2, 0, {29'd0, v}, r);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [1:0] ep, input logic [3:0] es,
                                       input logic [1:0] cp, input logic [4:0] sel,
                                       input logic [1:0] md);
        return {10'd0, ep, es, 2'd0, cp, 3'd0, sel, 1'b0, md, 1'b0};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        exp_cnt(0, 0, "R1"); exp_sh(1, 0, "R1"); exp_zero(3'b000, "R1");

        // R2 R3 mark-armed one-shot
        wr(2'd0, mk(2'b00, 4'h1, 2'b00, 5'd4, 2'b00));
        wr(2'd1, 3); wr(2'd2, 5); wr(2'd3, 2);
        exp_sh(2, 2, "R12");
        evt_lines = 32'h10;
        tick(3);
        exp_cnt(0, 3, "R3");
        mark_pulse = 1'b1; tick(1); mark_pulse = 1'b0;
        exp_cnt(1, 5, "R4");
        tick(1);
        exp_cnt(0, 2, "R4"); exp_cnt(1, 4, "R6");
        tick(1);
        exp_cnt(2, 0, "R7"); exp_zero(3'b100, "R11");
        tick(1);
        exp_cnt(0, 0, "R7"); exp_cnt(2, 0, "R7"); exp_cnt(1, 2, "R7");
        exp_zero(3'b001, "R11");
        tick(2);
        exp_cnt(1, 0, "R7"); exp_zero(3'b010, "R11");
        tick(2);
        exp_cnt(1, 0, "R7"); exp_zero(3'b000, "R11");

        // R8 armed cleared after last stop; R12 reload re-enables
        wr(2'd1, 2);
        tick(3);
        exp_cnt(0, 2, "R8");
        mark_pulse = 1'b1; tick(1); mark_pulse = 1'b0;
        tick(2);
        exp_cnt(0, 0, "R12"); exp_zero(3'b001, "R12");

        // R5 R6 counted privilege and select
        evt_lines = 32'h0;
        wr(2'd0, mk(2'b00, 4'hF, 2'b01, 5'd7, 2'b00));
        wr(2'd1, 10);
        evt_lines = 32'h40; priv_sup = 1'b0; tid_match = 1'b1;
        tick(3);
        exp_cnt(0, 10, "R6");
        evt_lines = 32'h80; priv_sup = 1'b1; tid_match = 1'b1;
        tick(3);
        exp_cnt(0, 10, "R5");
        priv_sup = 1'b0; tid_match = 1'b0;
        tick(3);
        exp_cnt(0, 10, "R5");
        tid_match = 1'b1;
        tick(4);
        exp_cnt(0, 6, "R6");

        // R3 R5 comparator arming with supervisor+ID filter
        evt_lines = 32'h0;
        wr(2'd0, mk(2'b11, 4'h3, 2'b00, 5'd0, 2'b00));
        wr(2'd1, 20);
        evt_lines = 32'h1;
        priv_sup = 1'b0; tid_match = 1'b1;
        cmp_evt = 6'b000010; tick(1); cmp_evt = '0;
        tick(3);
        exp_cnt(0, 20, "R5");
        priv_sup = 1'b1;
        cmp_evt = 6'b000001; tick(1); cmp_evt = '0;
        tick(3);
        exp_cnt(0, 20, "R3");
        cmp_evt = 6'b000010; tick(1); cmp_evt = '0;
        tick(3);
        exp_cnt(0, 17, "R4");

        // R8 control write clears armed
        wr(2'd0, mk(2'b11, 4'h3, 2'b00, 5'd0, 2'b00));
        exp_cnt(0, 16, "R8");
        tick(3);
        exp_cnt(0, 16, "R8");

        // R9 trace mode
        evt_lines = 32'h0; priv_sup = 1'b0; tid_match = 1'b0;
        wr(2'd0, mk(2'b00, 4'hF, 2'b00, 5'd0, 2'b01));
        wr(2'd1, 2); wr(2'd2, 100);
        exp_sh(0, 2, "R12"); exp_sh(1, 100, "R12");
        evt_lines = 32'h1;
        tick(2);
        exp_cnt(0, 0, "R9"); exp_zero(3'b001, "R11"); exp_cnt(1, 98, "R9");
        tick(1);
        exp_cnt(0, 32'hFFFF_FFFF, "R9"); exp_zero(3'b000, "R11");
        trace_req = 1'b1; tick(1); trace_req = 1'b0;
        exp_sh(0, 32'hFFFF_FFFF, "R9"); exp_cnt(0, 32'hFFFF_FFFE, "R9");
        exp_sh(1, 97, "R9"); exp_cnt(1, 96, "R9");
        tick(2);
        exp_sh(1, 97, "R9"); exp_cnt(1, 94, "R9");

        // R10 reserved mode; R3 reserved source
        evt_lines = 32'h0;
        wr(2'd0, mk(2'b00, 4'hF, 2'b00, 5'd0, 2'b10));
        wr(2'd1, 9);
        evt_lines = 32'h1;
        tick(3);
        exp_cnt(0, 9, "R10");
        wr(2'd0, mk(2'b00, 4'h8, 2'b00, 5'd0, 2'b00));
        tick(3);
        exp_cnt(0, 9, "R3");
        trace_req = 1'b1; tick(1); trace_req = 1'b0;
        exp_sh(0, 9, "R9");

        tick(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule